// File: doc/BRIEF.md
# Single-Cycle Move-Subset Processor Core

This block is a small processor core that completes one instruction on every clock edge. Its instruction set has six operations: a no-op, an unconditional jump, and four moves. The moves copy register to register, constant to register, memory to register and register to memory. Instructions are 1, 2, 9 or 10 bytes long, depending on the opcode byte.

In a single cycle the core does all of its work in combinational logic. It reads a ten-byte window at the PC and splits it into an opcode, two register specifiers and little-endian constants. It then reads two registers, forms a base-plus-displacement address in one adder and reads or writes data memory. The register result, any memory store and the new PC all take effect together at the next rising edge.

Instruction and data memories are byte arrays inside the core. A byte-wide load port fills them while reset is held. Observation ports show the PC, any chosen register and any eight-byte data word.

Top module: `mvp_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and all fifteen registers to 0. It leaves both memories unchanged.
- R2: Opcode byte 0x10 (no-op) changes no register or memory and advances the PC by 1.
- R3: Opcode byte 0x20 takes a second byte with the source specifier in bits 7:4 and the destination in bits 3:0. It copies the source register into the destination and advances the PC by 2.
- R4: Opcode byte 0x30 takes a second byte whose bits 3:0 name the destination, while bits 7:4 are ignored. It writes the little-endian 8-byte constant at PC+2..PC+9 into that register and advances the PC by 10.
- R5: Opcode byte 0x50 takes a second byte with the destination in bits 7:4 and the base register in bits 3:0. It loads the little-endian 8-byte word at base + displacement (displacement at PC+2..PC+9) into the destination and advances the PC by 10.
- R6: Opcode byte 0x40 takes a second byte with the data register in bits 7:4 and the base register in bits 3:0. It stores that register little-endian into the 8 bytes at base + displacement, writes no register and advances the PC by 10.
- R7: Opcode byte 0x70 loads the PC with the little-endian 8-byte value at PC+1..PC+8.
- R8: Register specifier 0xF means no register: it reads as zero and a write to it is dropped.
- R9: Any other opcode byte changes no register or memory and advances the PC by 1.
- R10: An instruction sees the register and memory results of the instruction before it, with no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Writes ld_data into a memory byte at the edge |
| ld_imem | input | 1 | 1 selects instruction memory, 0 selects data memory |
| ld_addr | input | LAW (8) | Byte address for the load port |
| ld_data | input | 8 | Byte to load |
| pc_o | output | 64 | Current PC |
| peek_reg_sel | input | 4 | Register to observe (0xF reads zero) |
| peek_reg_val | output | 64 | Value of the selected register |
| peek_addr | input | DAW (8) | Data-memory byte address to observe |
| peek_word | output | 64 | Little-endian 8-byte data word starting at peek_addr |

## Verification
Each instruction's effects are due one rising edge after its PC first appears on pc_o: the new PC, the register write and the memory store all land on that same edge. The bench releases reset on a falling edge and reads pc_o on every falling edge after that. It compares each reading against a precomputed trace, so every sample falls exactly one edge after the instruction that produced it. Register and memory results are read through the combinational observation ports once the program has settled into a self-jump loop. The reset checks are read on the falling edge after one reset edge.

// File: rtl/mvp_pkg.sv
package mvp_pkg;

    localparam int XLEN     = 64;
    localparam int SPEC_W   = 4;
    localparam int WIN_LEN  = 10;
    localparam logic [SPEC_W-1:0] SPEC_NONE = 4'hF;

    typedef enum logic [7:0] {
        OP_NOP   = 8'h10,
        OP_RRMOV = 8'h20,
        OP_IRMOV = 8'h30,
        OP_RMMOV = 8'h40,
        OP_MRMOV = 8'h50,
        OP_JMP   = 8'h70
    } opcode_e;

    typedef enum logic [1:0] {
        ALU_PASS_A = 2'd0,
        ALU_PASS_K = 2'd1,
        ALU_ADD_BK = 2'd2
    } alu_sel_e;

    typedef struct packed {
        logic [SPEC_W-1:0] src_a;
        logic [SPEC_W-1:0] src_b;
        logic [SPEC_W-1:0] dst_e;
        logic [SPEC_W-1:0] dst_m;
        logic              mem_wr;
        logic              jump;
        alu_sel_e          alu_sel;
        logic [3:0]        len;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

endpackage

// File: rtl/mvp_fetch.sv
module mvp_fetch
    import mvp_pkg::*;
#(
    parameter int IMEM_BYTES = 256,
    localparam int IAW = $clog2(IMEM_BYTES)
) (
    input  logic            clk,
    input  logic            ld_we,
    input  logic [IAW-1:0]  ld_addr,
    input  logic [7:0]      ld_data,
    input  logic [XLEN-1:0] pc,
    output logic [7:0]      op,
    output logic [3:0]      spec_hi,
    output logic [3:0]      spec_lo,
    output logic [XLEN-1:0] k_at1,
    output logic [XLEN-1:0] k_at2
);

    logic [7:0]     imem_q [IMEM_BYTES];
    logic [7:0]     win    [WIN_LEN];
    logic [IAW-1:0] pc_idx;

    assign pc_idx = pc[IAW-1:0];

    always_ff @(posedge clk) begin
        if (ld_we) begin
            imem_q[ld_addr] <= ld_data;
        end
    end

    for (genvar k = 0; k < WIN_LEN; k++) begin : g_win
        assign win[k] = imem_q[pc_idx + IAW'(k)];
    end

    for (genvar k = 0; k < 8; k++) begin : g_const
        assign k_at1[8*k +: 8] = win[k+1];
        assign k_at2[8*k +: 8] = win[k+2];
    end

    assign op      = win[0];
    assign spec_hi = win[1][7:4];
    assign spec_lo = win[1][3:0];

endmodule

// File: rtl/mvp_decode.sv
module mvp_decode
    import mvp_pkg::*;
(
    input  logic [7:0] op,
    input  logic [3:0] spec_hi,
    input  logic [3:0] spec_lo,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl         = '0;
        ctrl.src_a   = SPEC_NONE;
        ctrl.src_b   = SPEC_NONE;
        ctrl.dst_e   = SPEC_NONE;
        ctrl.dst_m   = SPEC_NONE;
        ctrl.alu_sel = ALU_PASS_A;
        ctrl.len     = 4'd1;
        case (op)
            OP_NOP: begin
                ctrl.len = 4'd1;
            end
            OP_RRMOV: begin
                ctrl.src_a   = spec_hi;
                ctrl.dst_e   = spec_lo;
                ctrl.alu_sel = ALU_PASS_A;
                ctrl.len     = 4'd2;
            end
            OP_IRMOV: begin
                ctrl.dst_e   = spec_lo;
                ctrl.alu_sel = ALU_PASS_K;
                ctrl.len     = 4'd10;
            end
            OP_RMMOV: begin
                ctrl.src_a   = spec_hi;
                ctrl.src_b   = spec_lo;
                ctrl.mem_wr  = 1'b1;
                ctrl.alu_sel = ALU_ADD_BK;
                ctrl.len     = 4'd10;
            end
            OP_MRMOV: begin
                ctrl.src_b   = spec_lo;
                ctrl.dst_m   = spec_hi;
                ctrl.alu_sel = ALU_ADD_BK;
                ctrl.len     = 4'd10;
            end
            OP_JMP: begin
                ctrl.jump = 1'b1;
                ctrl.len  = 4'd9;
            end
            default: begin
                ctrl.len = 4'd1;
            end
        endcase
    end

endmodule

// File: rtl/mvp_regfile.sv
module mvp_regfile
    import mvp_pkg::*;
#(
    parameter int NREGS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SPEC_W-1:0] src_a,
    input  logic [SPEC_W-1:0] src_b,
    input  logic [SPEC_W-1:0] src_c,
    output logic [XLEN-1:0]   val_a,
    output logic [XLEN-1:0]   val_b,
    output logic [XLEN-1:0]   val_c,
    input  logic [SPEC_W-1:0] dst_e,
    input  logic [XLEN-1:0]   wd_e,
    input  logic [SPEC_W-1:0] dst_m,
    input  logic [XLEN-1:0]   wd_m
);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    function automatic logic [XLEN-1:0] rd_sel(input logic [SPEC_W-1:0] sel,
                                               input logic [XLEN-1:0] arr [NREGS]);
        logic [XLEN-1:0] v;
        v = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (sel == SPEC_W'(i)) v = arr[i];
        end
        return v;
    endfunction

    assign val_a = rd_sel(src_a, regs_q);
    assign val_b = rd_sel(src_b, regs_q);
    assign val_c = rd_sel(src_c, regs_q);

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = regs_q[i];
            if (dst_e == SPEC_W'(i)) regs_d[i] = wd_e;
            if (dst_m == SPEC_W'(i)) regs_d[i] = wd_m;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    // R8: the "no register" specifier returns zero on every read port
    a_r8_none_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (src_a == SPEC_NONE) |-> (val_a == '0));
    a_r8_none_reads_zero_b: assert property (@(posedge clk) disable iff (rst)
        (src_b == SPEC_NONE) |-> (val_b == '0));

endmodule

// File: rtl/mvp_dmem.sv
module mvp_dmem
    import mvp_pkg::*;
#(
    parameter int DMEM_BYTES = 256,
    localparam int DAW = $clog2(DMEM_BYTES)
) (
    input  logic            clk,
    input  logic            ld_we,
    input  logic [DAW-1:0]  ld_addr,
    input  logic [7:0]      ld_data,
    input  logic [XLEN-1:0] acc_addr,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] rd_data,
    input  logic [DAW-1:0]  peek_addr,
    output logic [XLEN-1:0] peek_data
);

    logic [7:0]     mem_q [DMEM_BYTES];
    logic [DAW-1:0] acc_idx;

    assign acc_idx = acc_addr[DAW-1:0];

    for (genvar k = 0; k < 8; k++) begin : g_rd
        assign rd_data[8*k +: 8]   = mem_q[acc_idx + DAW'(k)];
        assign peek_data[8*k +: 8] = mem_q[peek_addr + DAW'(k)];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int k = 0; k < 8; k++) begin
                mem_q[acc_idx + DAW'(k)] <= wr_data[8*k +: 8];
            end
        end
        if (ld_we) begin
            mem_q[ld_addr] <= ld_data;
        end
    end

endmodule

// File: rtl/mvp_core.sv
module mvp_core
    import mvp_pkg::*;
#(
    parameter int IMEM_BYTES = 256,
    parameter int DMEM_BYTES = 256,
    parameter int NREGS      = 15,
    localparam int IAW = $clog2(IMEM_BYTES),
    localparam int DAW = $clog2(DMEM_BYTES),
    localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_imem,
    input  logic [LAW-1:0]    ld_addr,
    input  logic [7:0]        ld_data,
    output logic [XLEN-1:0]   pc_o,
    input  logic [SPEC_W-1:0] peek_reg_sel,
    output logic [XLEN-1:0]   peek_reg_val,
    input  logic [DAW-1:0]    peek_addr,
    output logic [XLEN-1:0]   peek_word
);

    core_state_t     st_d, st_q;
    logic [7:0]      op;
    logic [3:0]      spec_hi, spec_lo;
    logic [XLEN-1:0] k_at1, k_at2;
    ctrl_t           ctrl;
    logic [XLEN-1:0] val_a, val_b, alu_out, mem_rd;

    mvp_fetch #(.IMEM_BYTES(IMEM_BYTES)) fetch_i (
        .clk     (clk),
        .ld_we   (ld_en & ld_imem),
        .ld_addr (ld_addr[IAW-1:0]),
        .ld_data (ld_data),
        .pc      (st_q.pc),
        .op      (op),
        .spec_hi (spec_hi),
        .spec_lo (spec_lo),
        .k_at1   (k_at1),
        .k_at2   (k_at2)
    );

    mvp_decode decode_i (
        .op      (op),
        .spec_hi (spec_hi),
        .spec_lo (spec_lo),
        .ctrl    (ctrl)
    );

    mvp_regfile #(.NREGS(NREGS)) rf_i (
        .clk   (clk),
        .rst   (rst),
        .src_a (ctrl.src_a),
        .src_b (ctrl.src_b),
        .src_c (peek_reg_sel),
        .val_a (val_a),
        .val_b (val_b),
        .val_c (peek_reg_val),
        .dst_e (ctrl.dst_e),
        .wd_e  (alu_out),
        .dst_m (ctrl.dst_m),
        .wd_m  (mem_rd)
    );

    mvp_dmem #(.DMEM_BYTES(DMEM_BYTES)) dmem_i (
        .clk       (clk),
        .ld_we     (ld_en & ~ld_imem),
        .ld_addr   (ld_addr[DAW-1:0]),
        .ld_data   (ld_data),
        .acc_addr  (alu_out),
        .wr_en     (ctrl.mem_wr & ~rst),
        .wr_data   (val_a),
        .rd_data   (mem_rd),
        .peek_addr (peek_addr),
        .peek_data (peek_word)
    );

    always_comb begin
        unique case (ctrl.alu_sel)
            ALU_PASS_K: alu_out = k_at2;
            ALU_ADD_BK: alu_out = val_b + k_at2;
            default:    alu_out = val_a;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (ctrl.jump) st_d.pc = k_at1;
        else           st_d.pc = st_q.pc + XLEN'(ctrl.len);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign pc_o = st_q.pc;

    // R2: a no-op moves the PC by one byte
    a_r2_nop_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_NOP) |=> (st_q.pc == $past(st_q.pc) + 64'd1));
    // R3: register copy is two bytes long
    a_r3_copy_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RRMOV) |=> (st_q.pc == $past(st_q.pc) + 64'd2));
    // R4: constant and memory moves are ten bytes long
    a_r4_long_step: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IRMOV || op == OP_RMMOV || op == OP_MRMOV)
        |=> (st_q.pc == $past(st_q.pc) + 64'd10));
    // R7: a jump takes its target from the bytes after the opcode
    a_r7_jump_target: assert property (@(posedge clk) disable iff (rst)
        (op == OP_JMP) |=> (st_q.pc == $past(k_at1)));
    // R9: any unlisted opcode moves the PC by one byte
    a_r9_other_step: assert property (@(posedge clk) disable iff (rst)
        !(op inside {OP_NOP, OP_RRMOV, OP_IRMOV, OP_RMMOV, OP_MRMOV, OP_JMP})
        |=> (st_q.pc == $past(st_q.pc) + 64'd1));
    // R6: a store raises the memory write and leaves both register ports idle
    a_r6_store_quiet: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RMMOV) |-> (ctrl.mem_wr && ctrl.dst_e == SPEC_NONE
                              && ctrl.dst_m == SPEC_NONE));

endmodule

// File: tb/mvp_core_tb_top.sv
module mvp_core_tb_top;

    localparam int N_TRACE = 14;
    localparam logic [63:0] K1 = 64'h1122_3344_5566_7788;

    // Expected PC after reset release and after each executed edge.
    // Producing instruction: reset(R1), irmov(R4), irmov(R4), copy(R3), store(R6),
    // load(R5), nop(R2), unknown(R9), copy-to-none(R8), irmov(R4), load-base-none(R8),
    // jump(R7), copy(R3), jump(R7)
    localparam logic [63:0] PC_TRACE [N_TRACE] = '{
        64'd0, 64'd10, 64'd20, 64'd22, 64'd32, 64'd42, 64'd43,
        64'd44, 64'd46, 64'd56, 64'd66, 64'd100, 64'd102, 64'd102};
    localparam int PC_REQ [N_TRACE] = '{1, 4, 4, 3, 6, 5, 2, 9, 8, 4, 8, 7, 3, 7};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ld_en = 1'b0;
    logic        ld_imem = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [7:0]  ld_data = '0;
    logic [63:0] pc_o;
    logic [3:0]  peek_reg_sel = '0;
    logic [63:0] peek_reg_val;
    logic [7:0]  peek_addr = '0;
    logic [63:0] peek_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    logic [7:0]  img [256];
    logic [63:0] reg_exp [16];
    string       reg_tag [16];

    always #2 clk = ~clk;

    mvp_core dut_i (
        .clk          (clk),
        .rst          (rst),
        .ld_en        (ld_en),
        .ld_imem      (ld_imem),
        .ld_addr      (ld_addr),
        .ld_data      (ld_data),
        .pc_o         (pc_o),
        .peek_reg_sel (peek_reg_sel),
        .peek_reg_val (peek_reg_val),
        .peek_addr    (peek_addr),
        .peek_word    (peek_word)
    );

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put1(input int a, input logic [7:0] b);
        img[a] = b;
    endtask

    task automatic put8(input int a, input logic [63:0] v);
        for (int k = 0; k < 8; k++) img[a + k] = v[8*k +: 8];
    endtask

    task automatic read_reg(input logic [3:0] sel, output logic [63:0] v);
        peek_reg_sel = sel;
        #1 v = peek_reg_val;
    endtask

    task automatic read_mem(input logic [7:0] a, output logic [63:0] v);
        peek_addr = a;
        #1 v = peek_word;
    endtask

    initial begin
        logic [63:0] v;
        for (int i = 0; i < 256; i++) img[i] = 8'h00;
        put1(0, 8'h30);   put1(1, 8'hF1);   put8(2, K1);          // R4 r1 <- K1
        put1(10, 8'h30);  put1(11, 8'hF2);  put8(12, 64'h40);     // R4 r2 <- 0x40
        put1(20, 8'h20);  put1(21, 8'h13);                        // R3 r3 <- r1
        put1(22, 8'h40);  put1(23, 8'h32);  put8(24, 64'd8);      // R6 M[r2+8] <- r3
        put1(32, 8'h50);  put1(33, 8'h42);  put8(34, 64'd8);      // R5 r4 <- M[r2+8]
        put1(42, 8'h10);                                          // R2
        put1(43, 8'h60);                                          // R9
        put1(44, 8'h20);  put1(45, 8'h1F);                        // R8 write dropped
        put1(46, 8'h30);  put1(47, 8'h7E);  put8(48, 64'd5);      // R4 high nibble ignored
        put1(56, 8'h50);  put1(57, 8'h5F);  put8(58, 64'h48);     // R8 base reads zero
        put1(66, 8'h70);  put8(67, 64'd100);                      // R7
        put1(100, 8'h20); put1(101, 8'hE6);                       // R3 r6 <- r14
        put1(102, 8'h70); put8(103, 64'd102);                     // R7 self loop

        for (int i = 0; i < 16; i++) begin reg_exp[i] = '0; reg_tag[i] = "R9 untouched"; end
        reg_exp[1] = K1;      reg_tag[1]  = "R4 constant move";
        reg_exp[2] = 64'h40;  reg_tag[2]  = "R4 constant move";
        reg_exp[3] = K1;      reg_tag[3]  = "R3 register copy";
        reg_exp[4] = K1;      reg_tag[4]  = "R5 load via base";
        reg_exp[5] = K1;      reg_tag[5]  = "R8 none base";
        reg_exp[6] = 64'd5;   reg_tag[6]  = "R7 post-jump copy";
        reg_exp[14] = 64'd5;  reg_tag[14] = "R4 ignored nibble";
        reg_tag[15] = "R8 none reads zero";

        // load both memories while reset is held
        for (int i = 0; i < 512; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_imem = (i < 256);
            ld_addr = 8'(i);
            ld_data = (i < 256) ? img[i] : 8'h00;
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);

        // R1 reset state
        check64("R1 reset pc", pc_o, 64'd0);
        read_reg(4'd1, v);
        check64("R1 reset r1", v, 64'd0);

        rst = 1'b0;
        for (int i = 0; i < N_TRACE; i++) begin
            n_checks++;
            if (pc_o !== PC_TRACE[i]) begin
                n_fail++;
                $display("FAIL R%0d pc step %0d actual=%h expected=%h",
                         PC_REQ[i], i, pc_o, PC_TRACE[i]);
            end
            @(posedge clk);
            @(negedge clk);
        end

        for (int r = 0; r < 16; r++) begin
            read_reg(4'(r), v);
            check64($sformatf("%s r%0d", reg_tag[r], r), v, reg_exp[r]);
        end

        // R6 and R10: stored word is the copy made one instruction earlier
        read_mem(8'h48, v);
        check64("R6 R10 stored word", v, K1);
        read_mem(8'h40, v);
        check64("R6 no spill below", v, 64'd0);
        read_mem(8'h50, v);
        check64("R6 no spill above", v, 64'd0);

        // R1: reset again; registers clear, memory kept
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check64("R1 re-reset pc", pc_o, 64'd0);
        read_reg(4'd1, v);
        check64("R1 re-reset r1", v, 64'd0);
        read_reg(4'd14, v);
        check64("R1 re-reset r14", v, 64'd0);
        read_mem(8'h48, v);
        check64("R1 memory kept", v, K1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule